// File: doc/BRIEF.md
# 1-Wire master command engine

This block drives a single open-drain 1-Wire line on behalf of a host. The host presents an opcode and an argument byte with a one-cycle strobe. The engine then runs the whole bus operation by itself: a reset with presence detection, a single time slot, eight write slots, eight read slots, or a search step made of two reads and one write. When the operation ends, the engine leaves its results in status bits and in a read-data byte. While an operation is in progress the engine reports busy and drops any further command without acting on it.

All bus timing is counted in ticks of a divided reference clock. Two timing sets are supplied as packed words, one for standard speed and one for overdrive, and a select input chooses between them. Each set holds four fields: reset low time, presence sample offset, write-0 low time and recovery time. The write-1 low time and the data sample point are fixed tick counts given by parameters. An optional active pullup drives the line high for one tick after each release. An optional strong pullup keeps the line driven high after the last slot of a command. A power-down input stops all traffic.

Top module: `owm_engine`

## Requirements
- R1: After synchronous reset, busy, cmd_taken, line_pd and line_pu are 0, and every status bit and rd_data are 0.
- R2: A strobe is accepted only when the engine is idle, pwr_dn is 0 and cmd_op is 0 (reset), 1 (single bit), 2 (write byte), 3 (read byte) or 4 (search step). Acceptance gives a one-cycle cmd_taken in the next cycle, and busy is 1 from then until the operation ends. Any other strobe leaves cmd_taken at 0 and produces no bus activity.
- R3: A reset pulls the line low for F0 ticks and then releases it for F0 ticks, where F0 is bits [TW-1:0] of the selected timing word. st_sd is set when the line reads low one tick after release. st_ppd is set when the line reads low F1 ticks after release, where F1 is bits [2TW-1:TW].
- R4: A single-bit command sends a slot whose value is cmd_arg[7]. A 1 is sent as a low pulse of W1L_TICKS ticks and a 0 as a low pulse of F2 ticks, where F2 is bits [3TW-1:2TW]. The line is sampled SMP_TICKS ticks into the slot and the value is stored in st_sbr. Each slot lasts F2+F3 ticks, where F3 is bits [4TW-1:3TW].
- R5: A write byte sends the eight bits of cmd_arg as slots, least significant bit first.
- R6: A read byte sends eight 1 slots and assembles the sampled bits into rd_data, least significant bit first. rd_data changes only at the end of the command.
- R7: A search step records the first read in st_sbr and the second in st_tsb. It then writes a direction bit, which is also stored in st_dir. When both reads are 0, the direction is cmd_arg[7]. When the reads differ, the direction is the first read. When both reads are 1, the direction is 1 and st_terr is set.
- R8: cfg_od at 0 selects cfg_tstd and at 1 selects cfg_tod. All pulse widths scale with the selected fields.
- R9: With cfg_apu at 1, line_pu is high for exactly one tick after every release of the line.
- R10: With cfg_spu at 1 when a command is accepted, line_pu is driven from the release in the last slot and stays high until the next command is accepted or pwr_dn is asserted.
- R11: While pwr_dn is 1, line_pd and line_pu are 0 from the next cycle on, a running operation is abandoned, busy falls, and no command is accepted.
- R12: line_pd and line_pu are never 1 together. While the engine is idle, the status bits and rd_data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_arg | input | 8 | Argument byte |
| cfg_od | input | 1 | Selects the overdrive timing set |
| cfg_apu | input | 1 | Enables the active pullup after each release |
| cfg_spu | input | 1 | Arms the strong pullup for the next command |
| pwr_dn | input | 1 | Line power-down |
| cfg_tstd | input | 4*TW | Standard timing fields F0..F3 |
| cfg_tod | input | 4*TW | Overdrive timing fields F0..F3 |
| line_in | input | 1 | Sensed line level |
| line_pd | output | 1 | Pulls the line low |
| line_pu | output | 1 | Drives the line high |
| busy | output | 1 | Operation in progress |
| cmd_taken | output | 1 | Strobe was accepted |
| st_ppd | output | 1 | Presence detected |
| st_sd | output | 1 | Short detected |
| st_sbr | output | 1 | Single-bit or first search read |
| st_tsb | output | 1 | Second search read |
| st_dir | output | 1 | Search direction written |
| st_terr | output | 1 | Search reads were both 1 |
| rd_data | output | 8 | Read-byte result |

## Verification
A wrong slot counter or slot index shows at the ports as a low pulse of the wrong width, or as a missing or extra pulse. This is visible as soon as the affected pulse ends, so the bench compares every pulse width against a queue of expected widths. A wrong sample instant or a wrong search decision does not show while the command runs. It appears only in the status bits or rd_data after busy falls, so those values are compared at the end of each command. A sequencer left in the wrong state shows either as busy staying high, which the watchdog catches, or as a command being accepted or refused when it should not be, which is visible in cmd_taken one cycle after the strobe.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [2:0] {
    OP_RST   = 3'd0,
    OP_BIT   = 3'd1,
    OP_WBYTE = 3'd2,
    OP_RBYTE = 3'd3,
    OP_TRIP  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_GO   = 2'd1,
    S_WAIT = 2'd2
  } seq_e;

  function automatic logic op_ok(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic logic [2:0] op_last(input logic [2:0] op);
    case (op)
      3'd2, 3'd3: return 3'd7;
      3'd4:       return 3'd2;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/owm_slot.sv
module owm_slot #(
  parameter int TICK_DIV = 8,
  parameter int TW       = 8,
  parameter int W1L      = 1,
  parameter int SMP      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          is_rst,
  input  logic          wbit,
  input  logic          keep_pu,
  input  logic          apu_en,
  input  logic [TW-1:0] t_rstl,
  input  logic [TW-1:0] t_msp,
  input  logic [TW-1:0] t_w0l,
  input  logic [TW-1:0] t_rec,
  input  logic          line_in,
  output logic          pd,
  output logic          pu,
  output logic          done,
  output logic          smp_bit,
  output logic          ppd,
  output logic          sd
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = TW + 2;

  logic [PW-1:0] pre;
  logic [CW-1:0] t;
  logic          active, kind_rst, bitv, keep;
  logic          tick;
  logic [CW-1:0] low_len, smp_at, end_at;

  assign tick = active && (pre == PW'(TICK_DIV - 1));

  always_comb begin
    if (kind_rst) begin
      low_len = CW'(t_rstl);
      smp_at  = CW'(t_rstl) + CW'(t_msp);
      end_at  = (CW'(t_rstl) << 1) - CW'(1);
    end else begin
      low_len = bitv ? CW'(W1L) : CW'(t_w0l);
      smp_at  = CW'(SMP);
      end_at  = CW'(t_w0l) + CW'(t_rec) - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      t        <= '0;
      active   <= 1'b0;
      kind_rst <= 1'b0;
      bitv     <= 1'b0;
      keep     <= 1'b0;
      done     <= 1'b0;
      smp_bit  <= 1'b0;
      ppd      <= 1'b0;
      sd       <= 1'b0;
      pd       <= 1'b0;
      pu       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
      end else if (start) begin
        active   <= 1'b1;
        t        <= '0;
        pre      <= '0;
        kind_rst <= is_rst;
        bitv     <= wbit;
        keep     <= keep_pu;
      end else if (active) begin
        pre <= tick ? '0 : pre + PW'(1);
        if (tick) begin
          if (!kind_rst && t == smp_at) smp_bit <= line_in;
          if (kind_rst && t == CW'(t_rstl)) sd <= ~line_in;
          if (kind_rst && t == smp_at) ppd <= ~line_in;
          if (t == end_at) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            t <= t + CW'(1);
          end
        end
      end
      pd <= active && !abort && (t < low_len);
      pu <= active && !abort && (t >= low_len) &&
            ((apu_en && t == low_len) || keep);
    end
  end
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_arg,
  input  logic       pwr_dn,
  input  logic       cfg_spu,
  input  logic       slot_done,
  input  logic       slot_bit,
  input  logic       slot_ppd,
  input  logic       slot_sd,
  output logic       slot_start,
  output logic       slot_rst,
  output logic       slot_wbit,
  output logic       slot_keep,
  output logic       busy,
  output logic       taken,
  output logic       spu_hold,
  output logic       st_ppd,
  output logic       st_sd,
  output logic       st_sbr,
  output logic       st_tsb,
  output logic       st_dir,
  output logic       st_terr,
  output logic [7:0] rd_data
);
  seq_e       state;
  logic [2:0] op, idx, last;
  logic [7:0] arg, shreg;
  logic       spu_arm, accept;

  assign accept     = cmd_valid && (state == S_IDLE) && !pwr_dn && op_ok(cmd_op);
  assign busy       = (state != S_IDLE);
  assign slot_start = (state == S_GO);
  assign slot_rst   = (op == OP_RST);
  assign slot_keep  = spu_arm && (idx == last);

  always_comb begin
    case (op)
      OP_BIT:   slot_wbit = arg[7];
      OP_WBYTE: slot_wbit = arg[idx];
      OP_TRIP:  slot_wbit = (idx == 3'd2) ? st_dir : 1'b1;
      default:  slot_wbit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op       <= '0;
      arg      <= '0;
      idx      <= '0;
      last     <= '0;
      shreg    <= '0;
      spu_arm  <= 1'b0;
      spu_hold <= 1'b0;
      taken    <= 1'b0;
      st_ppd   <= 1'b0;
      st_sd    <= 1'b0;
      st_sbr   <= 1'b0;
      st_tsb   <= 1'b0;
      st_dir   <= 1'b0;
      st_terr  <= 1'b0;
      rd_data  <= '0;
    end else begin
      taken <= accept;
      case (state)
        S_IDLE: if (accept) begin
          op       <= cmd_op;
          arg      <= cmd_arg;
          idx      <= '0;
          last     <= op_last(cmd_op);
          spu_arm  <= cfg_spu;
          spu_hold <= 1'b0;
          state    <= S_GO;
        end
        S_GO: state <= S_WAIT;
        S_WAIT: if (slot_done) begin
          case (op)
            OP_RST: begin
              st_ppd <= slot_ppd;
              st_sd  <= slot_sd;
            end
            OP_BIT: st_sbr <= slot_bit;
            OP_RBYTE: begin
              shreg <= {slot_bit, shreg[7:1]};
              if (idx == last) rd_data <= {slot_bit, shreg[7:1]};
            end
            OP_TRIP: begin
              if (idx == 3'd0) st_sbr <= slot_bit;
              if (idx == 3'd1) begin
                st_tsb  <= slot_bit;
                st_dir  <= st_sbr | (~slot_bit & arg[7]);
                st_terr <= st_sbr & slot_bit;
              end
            end
            default: ;
          endcase
          if (idx == last) begin
            state    <= S_IDLE;
            spu_hold <= spu_arm;
          end else begin
            idx   <= idx + 3'd1;
            state <= S_GO;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (pwr_dn) begin
        state    <= S_IDLE;
        spu_hold <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/owm_engine.sv
module owm_engine #(
  parameter int TICK_DIV  = 8,
  parameter int TW        = 8,
  parameter int W1L_TICKS = 1,
  parameter int SMP_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [7:0]      cmd_arg,
  input  logic            cfg_od,
  input  logic            cfg_apu,
  input  logic            cfg_spu,
  input  logic            pwr_dn,
  input  logic [4*TW-1:0] cfg_tstd,
  input  logic [4*TW-1:0] cfg_tod,
  input  logic            line_in,
  output logic            line_pd,
  output logic            line_pu,
  output logic            busy,
  output logic            cmd_taken,
  output logic            st_ppd,
  output logic            st_sd,
  output logic            st_sbr,
  output logic            st_tsb,
  output logic            st_dir,
  output logic            st_terr,
  output logic [7:0]      rd_data
);
  localparam int NFLD = 4;

  logic [TW-1:0] fld [NFLD];
  logic slot_start, slot_rst, slot_wbit, slot_keep, slot_done;
  logic slot_bit, slot_ppd, slot_sd, slot_pu, spu_hold;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    assign fld[i] = cfg_od ? cfg_tod[i*TW +: TW] : cfg_tstd[i*TW +: TW];
  end

  owm_seq u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .pwr_dn(pwr_dn), .cfg_spu(cfg_spu),
    .slot_done(slot_done), .slot_bit(slot_bit), .slot_ppd(slot_ppd),
    .slot_sd(slot_sd), .slot_start(slot_start), .slot_rst(slot_rst),
    .slot_wbit(slot_wbit), .slot_keep(slot_keep), .busy(busy),
    .taken(cmd_taken), .spu_hold(spu_hold), .st_ppd(st_ppd), .st_sd(st_sd),
    .st_sbr(st_sbr), .st_tsb(st_tsb), .st_dir(st_dir), .st_terr(st_terr),
    .rd_data(rd_data)
  );

  owm_slot #(.TICK_DIV(TICK_DIV), .TW(TW), .W1L(W1L_TICKS), .SMP(SMP_TICKS)) u_slot (
    .clk(clk), .rst(rst), .start(slot_start), .abort(pwr_dn),
    .is_rst(slot_rst), .wbit(slot_wbit), .keep_pu(slot_keep),
    .apu_en(cfg_apu), .t_rstl(fld[0]), .t_msp(fld[1]), .t_w0l(fld[2]),
    .t_rec(fld[3]), .line_in(line_in), .pd(line_pd), .pu(slot_pu),
    .done(slot_done), .smp_bit(slot_bit), .ppd(slot_ppd), .sd(slot_sd)
  );

  assign line_pu = slot_pu | spu_hold;
endmodule

// File: rtl/owm_engine_chk.sv
module owm_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       pwr_dn,
  input logic       line_pd,
  input logic       line_pu,
  input logic       busy,
  input logic       cmd_taken,
  input logic       st_ppd,
  input logic       st_sd,
  input logic       st_sbr,
  input logic       st_tsb,
  input logic       st_dir,
  input logic       st_terr,
  input logic [7:0] rd_data
);
  a_r2_refuse_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> !cmd_taken);

  a_r2_refuse_bad_op: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op > 3'd4) |=> !cmd_taken);

  a_r2_taken_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_taken |-> busy);

  a_r3_pd_only_busy: assert property (@(posedge clk) disable iff (rst)
    line_pd |-> busy);

  a_r11_line_quiet: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!line_pd && !line_pu && !busy));

  a_r11_no_accept: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> !cmd_taken);

  a_r12_no_fight: assert property (@(posedge clk) disable iff (rst)
    !(line_pd && line_pu));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable({st_ppd, st_sd, st_sbr, st_tsb, st_dir, st_terr, rd_data}));
endmodule

bind owm_engine owm_engine_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .pwr_dn(pwr_dn), .line_pd(line_pd), .line_pu(line_pu), .busy(busy),
  .cmd_taken(cmd_taken), .st_ppd(st_ppd), .st_sd(st_sd), .st_sbr(st_sbr),
  .st_tsb(st_tsb), .st_dir(st_dir), .st_terr(st_terr), .rd_data(rd_data)
);

// File: tb/tb_owm_engine.sv
module tb_owm_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int TW  = 8;
  localparam int W1L = 1;
  localparam int SMP = 2;
  localparam int S_RSTL = 20, S_MSP = 6, S_W0L = 8, S_REC = 2;
  localparam int O_RSTL = 10, O_MSP = 4, O_W0L = 5, O_REC = 1;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cfg_od = 0, cfg_apu = 0, cfg_spu = 0, pwr_dn = 0;
  logic [2:0] cmd_op = 0;
  logic [7:0] cmd_arg = 0;
  logic [4*TW-1:0] cfg_tstd, cfg_tod;
  logic line_in, line_pd, line_pu, busy, cmd_taken;
  logic st_ppd, st_sd, st_sbr, st_tsb, st_dir, st_terr;
  logic [7:0] rd_data;
  logic slave_pull = 0, short_line = 0;
  bit   rst_mode = 0, pres_en = 0, chk_w = 1;
  int   total = 0, bad = 0, pdcnt = 0, pucnt = 0;
  int   wq[$];
  bit   rq[$];
  string w_tag = "R4";

  assign cfg_tstd = {8'(S_REC), 8'(S_W0L), 8'(S_MSP), 8'(S_RSTL)};
  assign cfg_tod  = {8'(O_REC), 8'(O_W0L), 8'(O_MSP), 8'(O_RSTL)};
  assign line_in  = !(line_pd | slave_pull | short_line);

  always #(CLK_PERIOD/2) clk = ~clk;

  owm_engine #(.TICK_DIV(DIV), .TW(TW), .W1L_TICKS(W1L), .SMP_TICKS(SMP)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cfg_od(cfg_od), .cfg_apu(cfg_apu), .cfg_spu(cfg_spu),
    .pwr_dn(pwr_dn), .cfg_tstd(cfg_tstd), .cfg_tod(cfg_tod),
    .line_in(line_in), .line_pd(line_pd), .line_pu(line_pu), .busy(busy),
    .cmd_taken(cmd_taken), .st_ppd(st_ppd), .st_sd(st_sd), .st_sbr(st_sbr),
    .st_tsb(st_tsb), .st_dir(st_dir), .st_terr(st_terr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural slave: scripted reply bit per slot
  always @(posedge line_pd) begin
    bit b;
    if (!rst_mode && rq.size() > 0) begin
      b = rq.pop_front();
      if (!b) begin
        slave_pull <= 1'b1;
        repeat ((SMP + 2) * DIV) @(posedge clk);
        slave_pull <= 1'b0;
      end
    end
  end

  // behavioural slave: presence pulse after a reset release
  always @(negedge line_pd) begin
    if (rst_mode && pres_en) begin
      repeat (DIV + 2) @(posedge clk);
      slave_pull <= 1'b1;
      repeat (((cfg_od ? O_MSP : S_MSP) + 2) * DIV) @(posedge clk);
      slave_pull <= 1'b0;
    end
  end

  // reference model: queue of expected low-pulse widths, compared every clock
  always @(negedge clk) begin
    if (line_pu === 1'b1) pucnt++;
    if (line_pd === 1'b1) pdcnt++;
    else if (pdcnt > 0) begin
      if (chk_w) begin
        if (wq.size() == 0) chk(0, w_tag, pdcnt, 0);
        else begin
          int e;
          e = wq.pop_front();
          chk(pdcnt == e, w_tag, pdcnt, e);
        end
      end
      pdcnt = 0;
    end
  end

  function automatic int wslot(input bit v);
    if (v) return W1L * DIV;
    return (cfg_od ? O_W0L : S_W0L) * DIV;
  endfunction

  task automatic cmd(input logic [2:0] op, input logic [7:0] arg, output bit tk);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0;
    tk = cmd_taken;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit pres, input bit shrt, input int e_ppd, input int e_sd);
    bit tk;
    rst_mode = 1; pres_en = pres; short_line = shrt; w_tag = "R3";
    wq.push_back((cfg_od ? O_RSTL : S_RSTL) * DIV);
    cmd(3'd0, 8'h00, tk);
    chk(tk, "R2 accept", tk, 1);
    wait_idle();
    chk(st_ppd == e_ppd, "R3 ppd", st_ppd, e_ppd);
    chk(st_sd == e_sd, "R3 sd", st_sd, e_sd);
    rst_mode = 0; pres_en = 0; short_line = 0;
  endtask

  task automatic do_bit(input logic [7:0] arg, input bit reply, input int e);
    bit tk;
    w_tag = "R4";
    rq.push_back(reply);
    wq.push_back(wslot(arg[7]));
    cmd(3'd1, arg, tk);
    wait_idle();
    chk(st_sbr == e, "R4 sbr", st_sbr, e);
  endtask

  task automatic do_rbyte(input logic [7:0] v, input string tag);
    bit tk;
    w_tag = tag;
    for (int i = 0; i < 8; i++) begin
      rq.push_back(v[i]);
      wq.push_back(wslot(1));
    end
    cmd(3'd3, 8'h00, tk);
    wait_idle();
    chk(rd_data == v, tag, rd_data, v);
  endtask

  task automatic do_trip(input bit a, input bit b, input bit p, input bit e_dir, input bit e_err);
    bit tk;
    w_tag = "R7";
    rq.push_back(a); rq.push_back(b); rq.push_back(1'b1);
    wq.push_back(wslot(1)); wq.push_back(wslot(1)); wq.push_back(wslot(e_dir));
    cmd(3'd4, {p, 7'h00}, tk);
    wait_idle();
    chk(st_sbr == a, "R7 first read", st_sbr, a);
    chk(st_tsb == b, "R7 second read", st_tsb, b);
    chk(st_dir == e_dir, "R7 direction", st_dir, e_dir);
    chk(st_terr == e_err, "R7 error", st_terr, e_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit tk;
    logic [13:0] snap;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_taken && !line_pd && !line_pu, "R1 controls", {busy, line_pd, line_pu}, 0);
    chk({st_ppd, st_sd, st_sbr, st_tsb, st_dir, st_terr, rd_data} == 0, "R1 results",
        {st_ppd, st_sd, st_sbr, st_tsb, st_dir, st_terr, rd_data}, 0);

    // R3 reset variants
    do_reset(1, 0, 1, 0);
    do_reset(0, 0, 0, 0);
    do_reset(0, 1, 1, 1);

    // R4 single slots
    do_bit(8'h80, 0, 0);
    do_bit(8'h80, 1, 1);
    do_bit(8'h00, 1, 0);

    // R5 write byte, LSB first (widths checked by the model)
    w_tag = "R5";
    for (int i = 0; i < 8; i++) begin
      rq.push_back(1'b1);
      wq.push_back(wslot(8'hA5 >> i));
    end
    cmd(3'd2, 8'hA5, tk);
    wait_idle();
    chk(wq.size() == 0, "R5 all slots sent", wq.size(), 0);

    // R6 read byte
    do_rbyte(8'h3C, "R6");
    // R8 overdrive timing
    cfg_od = 1;
    do_rbyte(8'hC9, "R8");
    do_reset(1, 0, 1, 0);
    cfg_od = 0;

    // R7 search steps
    do_trip(0, 0, 1, 1, 0);
    do_trip(0, 0, 0, 0, 0);
    do_trip(0, 1, 1, 0, 0);
    do_trip(1, 0, 0, 1, 0);
    do_trip(1, 1, 0, 1, 1);

    // R2 refusal while busy, R6 result untouched by refused command
    w_tag = "R2";
    for (int i = 0; i < 8; i++) begin
      rq.push_back(8'h5A >> i);
      wq.push_back(wslot(1));
    end
    cmd(3'd3, 8'h00, tk);
    cmd(3'd0, 8'h00, tk);
    chk(!tk, "R2 busy refusal", tk, 0);
    wait_idle();
    chk(rd_data == 8'h5A, "R6 after refusal", rd_data, 8'h5A);
    chk(wq.size() == 0, "R2 no extra slot", wq.size(), 0);

    // R2 bad opcode, R12 idle status hold
    snap = {st_ppd, st_sd, st_sbr, st_tsb, st_dir, st_terr, rd_data};
    cmd(3'd7, 8'hFF, tk);
    chk(!tk, "R2 bad opcode", tk, 0);
    @(negedge clk);
    chk(!busy && !line_pd, "R2 no activity", busy, 0);
    chk({st_ppd, st_sd, st_sbr, st_tsb, st_dir, st_terr, rd_data} == snap, "R12 idle hold",
        {st_ppd, st_sd, st_sbr, st_tsb, st_dir, st_terr, rd_data}, snap);

    // R9 active pullup: one tick after the single release
    cfg_apu = 1; pucnt = 0;
    do_bit(8'h80, 1, 1);
    chk(pucnt == DIV, "R9 pullup width", pucnt, DIV);
    cfg_apu = 0;

    // R10 strong pullup holds after the command
    cfg_spu = 1;
    do_bit(8'h80, 1, 1);
    cfg_spu = 0;
    repeat (10) @(negedge clk);
    chk(line_pu == 1, "R10 hold", line_pu, 1);
    do_bit(8'h80, 1, 1);
    chk(line_pu == 0, "R10 released by next command", line_pu, 0);

    // R11 power down
    pwr_dn = 1;
    cmd(3'd0, 8'h00, tk);
    chk(!tk, "R11 refused", tk, 0);
    repeat (5) @(negedge clk);
    chk(!line_pd && !busy, "R11 quiet", {line_pd, busy}, 0);
    pwr_dn = 0;
    chk_w = 0;
    for (int i = 0; i < 8; i++) rq.push_back(1'b1);
    cmd(3'd2, 8'h00, tk);
    repeat (20) @(negedge clk);
    pwr_dn = 1;
    @(negedge clk);
    chk(!busy && !line_pd && !line_pu, "R11 abort", {busy, line_pd, line_pu}, 0);
    @(negedge clk);
    pwr_dn = 0;
    wq.delete(); rq.delete();
    repeat (2) @(negedge clk);
    chk_w = 1;
    do_reset(1, 0, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule